// File: doc/BRIEF.md
# Fracturable Multiplier Block

This block is a two-stage pipelined multiplier whose partial-product array can be carved up at run time. A two-bit mode input picks one of three groupings of the same set of 9x9 sub-multipliers. It can work as eight independent 9-bit lanes, as four independent 18-bit lanes, or as one 36-bit multiplier. The 72-bit operand buses are split into lane slices, and each lane's product is packed into its own field of a 144-bit output bus. One sign-mode input makes every lane treat its operands as two's complement or as unsigned.

The input stage holds the A operand as four 18-bit segment registers. A shift control turns these registers into a chain, so that one operand stream entering on the lowest A slice can be spread across lanes over successive cycles. A single clock enable gates both register stages, and an asynchronous active-low reset clears them.

Top module: `fmul_top`

## Requirements
- R1: While reset is asserted and at the first clock after its release, `p_out` is all zeros.
- R2: Mode 0: for each k in 0..7, `p_out[18k+17:18k]` is the product of `a_in[9k+8:9k]` and `b_in[9k+8:9k]`.
- R3: Mode 1: for each k in 0..3, `p_out[36k+35:36k]` is the product of `a_in[18k+17:18k]` and `b_in[18k+17:18k]`.
- R4: Mode 2: `p_out[71:0]` is the product of `a_in[35:0]` and `b_in[35:0]`, and `p_out[143:72]` is zero.
- R5: Mode 3 yields an all-zero product.
- R6: With `sign_en` = 1, every lane reads its operand slices as two's complement at the lane width and writes a two's complement product of twice that width. With `sign_en` = 0 the slices are read as unsigned.
- R7: Operands, mode and sign presented on one enabled edge appear on `p_out` after the next enabled edge, which is a latency of two cycles while `en` stays high.
- R8: When `en` is low at an edge, no register changes and `p_out` holds its value.
- R9: On an enabled edge with `shift_en` = 1, A segment s (bits 18s+17:18s) loads the previous contents of segment s-1. Segment 0 loads `a_in[17:0]`, and `a_in[71:18]` is ignored. B, mode and sign load from their inputs as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Clock enable for both register stages |
| shift_en | input | 1 | Load the A segments as a shift chain |
| sign_en | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mode | input | 2 | 0: 8 x 9x9, 1: 4 x 18x18, 2: 1 x 36x36, 3: zero |
| a_in | input | 72 | Operand A bus |
| b_in | input | 72 | Operand B bus |
| p_out | output | 144 | Packed product bus |

## Verification
The hardest case to reach from the ports is a shift-chain load that is followed by a product. Each A segment then holds data that entered on the lowest slice several cycles earlier, and every other bit of `a_in` must have had no effect. The stimulus shifts four distinct values in, with noise on the upper A bits. It sets each B lane to one in 18-bit mode, so that every lane of the output shows its segment's contents. A cycle model in the bench tracks those contents, with the enable dropped at random. Directed operands test the sign boundaries of each lane width: most negative times most negative, most negative times most positive, and all ones.

// File: rtl/fmul_pkg.sv
package fmul_pkg;

  localparam int CHUNK_W    = 9;
  localparam int NUM_CHUNKS = 8;
  localparam int MID_GRP    = 2;   // chunks per operand in 18-bit mode
  localparam int WIDE_GRP   = 4;   // chunks per operand in 36-bit mode

  typedef enum logic [1:0] {
    MODE_NARROW = 2'd0,
    MODE_MID    = 2'd1,
    MODE_WIDE   = 2'd2,
    MODE_OFF    = 2'd3
  } fmul_mode_e;

  // A sub-multiplier (i,j) multiplies A chunk i by B chunk j.
  // Only pairs that some mode combines are built.
  function automatic bit pair_used(int i, int j);
    return (i == j) ||
           ((i / MID_GRP) == (j / MID_GRP)) ||
           ((i / WIDE_GRP) == 0 && (j / WIDE_GRP) == 0);
  endfunction

  // A chunk carries the sign of its operand when it is the top chunk
  // of that operand in the current grouping.
  function automatic logic chunk_top(int i, fmul_mode_e m);
    logic r;
    case (m)
      MODE_NARROW: r = 1'b1;
      MODE_MID:    r = ((i % MID_GRP) == MID_GRP - 1);
      MODE_WIDE:   r = (i == WIDE_GRP - 1);
      default:     r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fmul_instage.sv
module fmul_instage #(
  parameter int CW = fmul_pkg::CHUNK_W,
  parameter int NC = fmul_pkg::NUM_CHUNKS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 shift_en,
  input  logic                 sign_en,
  input  fmul_pkg::fmul_mode_e mode_in,
  input  logic [CW*NC-1:0]     a_in,
  input  logic [CW*NC-1:0]     b_in,
  output logic [CW*NC-1:0]     a_q,
  output logic [CW*NC-1:0]     b_q,
  output fmul_pkg::fmul_mode_e mode_q,
  output logic                 sign_q
);
  localparam int OPW   = CW * NC;
  localparam int SEG_W = CW * fmul_pkg::MID_GRP;
  localparam int NSEG  = OPW / SEG_W;

  logic [OPW-1:0]       a_d, b_d;
  fmul_pkg::fmul_mode_e mode_d;
  logic                 sign_d;
  logic [OPW-1:0]       a_shifted;

  // shift path: segment 0 from the bus, segment s from segment s-1
  assign a_shifted[SEG_W-1:0] = a_in[SEG_W-1:0];
  for (genvar s = 1; s < NSEG; s++) begin : g_chain
    assign a_shifted[s*SEG_W +: SEG_W] = a_q[(s-1)*SEG_W +: SEG_W];
  end

  always_comb begin
    a_d    = a_q;
    b_d    = b_q;
    mode_d = mode_q;
    sign_d = sign_q;
    if (en) begin
      a_d    = shift_en ? a_shifted : a_in;
      b_d    = b_in;
      mode_d = mode_in;
      sign_d = sign_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= fmul_pkg::MODE_NARROW;
      sign_q <= 1'b0;
    end else begin
      a_q    <= a_d;
      b_q    <= b_d;
      mode_q <= mode_d;
      sign_q <= sign_d;
    end
  end
endmodule

// File: rtl/fmul_pp.sv
module fmul_pp #(
  parameter int CW = fmul_pkg::CHUNK_W
) (
  input  logic [CW-1:0]   a_chunk,
  input  logic [CW-1:0]   b_chunk,
  input  logic            a_signed,
  input  logic            b_signed,
  output logic [2*CW+1:0] prod
);
  logic signed [CW:0]     a_x, b_x;
  logic signed [2*CW+1:0] prod_s;

  // one extra bit: sign copy for a top chunk, zero for an inner one
  assign a_x    = {a_signed & a_chunk[CW-1], a_chunk};
  assign b_x    = {b_signed & b_chunk[CW-1], b_chunk};
  assign prod_s = a_x * b_x;
  assign prod   = prod_s;
endmodule

// File: rtl/fmul_combine.sv
module fmul_combine #(
  parameter int CW = fmul_pkg::CHUNK_W,
  parameter int NC = fmul_pkg::NUM_CHUNKS
) (
  input  logic [NC*NC*(2*CW+2)-1:0] pp_flat,
  input  fmul_pkg::fmul_mode_e      mode,
  output logic [2*CW*NC-1:0]        prod
);
  localparam int PPW    = 2 * CW + 2;
  localparam int MG     = fmul_pkg::MID_GRP;
  localparam int WG     = fmul_pkg::WIDE_GRP;
  localparam int NAR_W  = 2 * CW;
  localparam int MID_W  = 2 * CW * MG;
  localparam int WIDE_W = 2 * CW * WG;
  localparam int NMID   = NC / MG;

  logic [PPW-1:0]    cur;
  logic [MID_W-1:0]  acc_mid;
  logic [WIDE_W-1:0] acc_wide;

  always_comb begin
    prod     = '0;
    cur      = '0;
    acc_mid  = '0;
    acc_wide = '0;
    case (mode)
      fmul_pkg::MODE_NARROW: begin
        for (int k = 0; k < NC; k++) begin
          cur = pp_flat[(k*NC + k)*PPW +: PPW];
          prod[k*NAR_W +: NAR_W] = cur[NAR_W-1:0];
        end
      end
      fmul_pkg::MODE_MID: begin
        for (int l = 0; l < NMID; l++) begin
          acc_mid = '0;
          for (int i = 0; i < MG; i++) begin
            for (int j = 0; j < MG; j++) begin
              cur = pp_flat[((l*MG + i)*NC + l*MG + j)*PPW +: PPW];
              acc_mid = acc_mid +
                ({{(MID_W-PPW){cur[PPW-1]}}, cur} << (CW*(i+j)));
            end
          end
          prod[l*MID_W +: MID_W] = acc_mid;
        end
      end
      fmul_pkg::MODE_WIDE: begin
        for (int i = 0; i < WG; i++) begin
          for (int j = 0; j < WG; j++) begin
            cur = pp_flat[(i*NC + j)*PPW +: PPW];
            acc_wide = acc_wide +
              ({{(WIDE_W-PPW){cur[PPW-1]}}, cur} << (CW*(i+j)));
          end
        end
        prod[WIDE_W-1:0] = acc_wide;
      end
      default: prod = '0;
    endcase
  end
endmodule

// File: rtl/fmul_top.sv
module fmul_top #(
  parameter int CW = fmul_pkg::CHUNK_W,
  parameter int NC = fmul_pkg::NUM_CHUNKS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              shift_en,
  input  logic              sign_en,
  input  logic [1:0]        mode,
  input  logic [CW*NC-1:0]  a_in,
  input  logic [CW*NC-1:0]  b_in,
  output logic [2*CW*NC-1:0] p_out
);
  localparam int OPW = CW * NC;
  localparam int PW  = 2 * OPW;
  localparam int PPW = 2 * CW + 2;

  logic [OPW-1:0]          a_q, b_q;
  fmul_pkg::fmul_mode_e    mode_q;
  logic                    sign_q;
  logic [NC-1:0]           top_sgn;
  logic [NC*NC*PPW-1:0]    pp_flat;
  logic [PW-1:0]           prod_c;
  logic [PW-1:0]           p_d, p_q;

  fmul_instage #(.CW(CW), .NC(NC)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .shift_en (shift_en),
    .sign_en  (sign_en),
    .mode_in  (fmul_pkg::fmul_mode_e'(mode)),
    .a_in     (a_in),
    .b_in     (b_in),
    .a_q      (a_q),
    .b_q      (b_q),
    .mode_q   (mode_q),
    .sign_q   (sign_q)
  );

  always_comb begin
    for (int i = 0; i < NC; i++) begin
      top_sgn[i] = sign_q & fmul_pkg::chunk_top(i, mode_q);
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_row
    for (genvar j = 0; j < NC; j++) begin : g_col
      if (fmul_pkg::pair_used(i, j)) begin : g_mul
        fmul_pp #(.CW(CW)) u_pp (
          .a_chunk  (a_q[i*CW +: CW]),
          .b_chunk  (b_q[j*CW +: CW]),
          .a_signed (top_sgn[i]),
          .b_signed (top_sgn[j]),
          .prod     (pp_flat[(i*NC + j)*PPW +: PPW])
        );
      end else begin : g_none
        assign pp_flat[(i*NC + j)*PPW +: PPW] = '0;
      end
    end
  end

  fmul_combine #(.CW(CW), .NC(NC)) u_comb (
    .pp_flat (pp_flat),
    .mode    (mode_q),
    .prod    (prod_c)
  );

  always_comb begin
    p_d = p_q;
    if (en) p_d = prod_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= '0;
    else        p_q <= p_d;
  end

  assign p_out = p_q;
endmodule

// File: rtl/fmul_chk.sv
module fmul_chk #(
  parameter int CW = fmul_pkg::CHUNK_W,
  parameter int NC = fmul_pkg::NUM_CHUNKS
) (
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                shift_en,
  input logic                sign_en,
  input logic [1:0]          mode,
  input logic [CW*NC-1:0]    a_in,
  input logic [CW*NC-1:0]    b_in,
  input logic [2*CW*NC-1:0]  p_out
);
  localparam int NW   = 2 * CW;
  localparam int MW   = 4 * CW;
  localparam int HALF = CW * NC;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(p_out));

  assert_off_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(mode) == 2'd3) |=> (p_out == '0));

  assert_wide_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(mode) == 2'd2) |=> (p_out[2*HALF-1:HALF] == '0));

  assert_narrow_lane0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(mode) == 2'd0 && !$past(sign_en) && !$past(shift_en))
    |=> (p_out[NW-1:0] == NW'($past(a_in[CW-1:0], 2)) * NW'($past(b_in[CW-1:0], 2))));

  assert_mid_lane0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(mode) == 2'd1 && !$past(sign_en) && !$past(shift_en))
    |=> (p_out[MW-1:0] == MW'($past(a_in[2*CW-1:0], 2)) * MW'($past(b_in[2*CW-1:0], 2))));
endmodule

bind fmul_top fmul_chk #(.CW(CW), .NC(NC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .shift_en (shift_en),
  .sign_en  (sign_en),
  .mode     (mode),
  .a_in     (a_in),
  .b_in     (b_in),
  .p_out    (p_out)
);

// File: tb/fmul_top_tb.sv
module fmul_top_tb;
  logic         clk;
  logic         rst_n;
  logic         en, shift_en, sign_en;
  logic [1:0]   mode;
  logic [71:0]  a_in, b_in;
  logic [143:0] p_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // bench-side cycle model
  logic [71:0]  m_a, m_b;
  logic [1:0]   m_mode;
  logic         m_sgn;
  string        m_tag;
  logic [143:0] m_p;
  string        p_tag;

  fmul_top u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .shift_en(shift_en),
    .sign_en(sign_en), .mode(mode), .a_in(a_in), .b_in(b_in), .p_out(p_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [143:0] mulx(logic [71:0] a, logic [71:0] b, int w, bit sg);
    logic [143:0] mask, ax, bx, m;
    mask = (144'(1) << w) - 144'(1);
    ax = 144'(a) & mask;
    bx = 144'(b) & mask;
    if (sg && a[w-1]) ax = ax | ~mask;
    if (sg && b[w-1]) bx = bx | ~mask;
    m = ax * bx;
    return m & ((144'(1) << (2*w)) - 144'(1));
  endfunction

  function automatic logic [143:0] calc(logic [71:0] a, logic [71:0] b, logic [1:0] md, bit sg);
    logic [143:0] r, t;
    r = '0;
    case (md)
      2'd0: for (int k = 0; k < 8; k++) begin
              t = mulx(72'(a[9*k +: 9]), 72'(b[9*k +: 9]), 9, sg);
              r[18*k +: 18] = t[17:0];
            end
      2'd1: for (int k = 0; k < 4; k++) begin
              t = mulx(72'(a[18*k +: 18]), 72'(b[18*k +: 18]), 18, sg);
              r[36*k +: 36] = t[35:0];
            end
      2'd2: begin
              t = mulx(72'(a[35:0]), 72'(b[35:0]), 36, sg);
              r[71:0] = t[71:0];
            end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string mode_tag(logic [1:0] md, bit sg);
    if (md == 2'd3) return "R5";
    if (sg) return "R6";
    case (md)
      2'd0: return "R2";
      2'd1: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req);
    n_tests++;
    if (p_out !== m_p) begin
      n_fail++;
      $display("FAIL %s: p_out actual %h expected %h", req, p_out, m_p);
    end
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic step(logic [71:0] a, logic [71:0] b, logic [1:0] md,
                      bit sg, bit sh, bit e, string tag);
    a_in = a; b_in = b; mode = md; sign_en = sg; shift_en = sh; en = e;
    @(posedge clk);
    if (e) begin
      m_p   = calc(m_a, m_b, m_mode, m_sgn);
      p_tag = (m_tag != "") ? m_tag : mode_tag(m_mode, m_sgn);
      if (sh) m_a = {m_a[53:0], a[17:0]};
      else    m_a = a;
      m_b = b; m_mode = md; m_sgn = sg; m_tag = tag;
    end
    @(negedge clk);
    check(e ? p_tag : "R8");
  endtask

  function automatic logic [71:0] rnd72();
    return {$urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [71:0] mins [3];
    logic [71:0] maxs [3];
    seed = $urandom(32'h5EED_1234);
    m_a = '0; m_b = '0; m_mode = 2'd0; m_sgn = 1'b0; m_tag = ""; m_p = '0;
    rst_n = 1'b0; en = 1'b1; shift_en = 1'b0; sign_en = 1'b1; mode = 2'd1;
    a_in = '1; b_in = '1;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    // first enabled edge after reset computes from the cleared stage: zero (R1)
    step(72'h0, 72'h0, 2'd0, 1'b0, 1'b0, 1'b1, "");
    n_tests++;
    if (p_out !== '0) begin
      n_fail++;
      $display("FAIL R1: p_out actual %h expected 0", p_out);
    end

    // R7: one operand set, then a different one; result shows after 2nd edge
    step({8{9'd3}}, {8{9'd5}}, 2'd0, 1'b0, 1'b0, 1'b1, "R7");
    step({8{9'd7}}, {8{9'd11}}, 2'd0, 1'b0, 1'b0, 1'b1, "R7");
    step(72'h0, 72'h0, 2'd0, 1'b0, 1'b0, 1'b1, "");

    // corner values per mode and sign
    mins[0] = {8{9'h100}};  maxs[0] = {8{9'h0FF}};
    mins[1] = {4{18'h20000}}; maxs[1] = {4{18'h1FFFF}};
    mins[2] = {36'h0, 36'h8_0000_0000}; maxs[2] = {36'h0, 36'h7_FFFF_FFFF};
    for (int md = 0; md < 3; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        step(mins[md], mins[md], 2'(md), 1'(sg), 1'b0, 1'b1, "");
        step(mins[md], maxs[md], 2'(md), 1'(sg), 1'b0, 1'b1, "");
        step('1, '1, 2'(md), 1'(sg), 1'b0, 1'b1, "");
        step(maxs[md], maxs[md], 2'(md), 1'(sg), 1'b0, 1'b1, "");
      end
    end
    // mode 3 with full operands (R5), including upper bits in wide mode (R4)
    step('1, '1, 2'd3, 1'b1, 1'b0, 1'b1, "R5");
    step(rnd72(), rnd72(), 2'd2, 1'b0, 1'b0, 1'b1, "R4");
    step(rnd72(), rnd72(), 2'd0, 1'b0, 1'b0, 1'b1, "");

    // R9: shift four values in via a_in[17:0], upper bits noisy
    for (int s = 0; s < 4; s++)
      step({rnd72() & ~72'h3FFFF} | 72'(18'h1000 + s*18'h0111 + 18'h20000*(s%2)),
           {4{18'd1}}, 2'd1, 1'b0, 1'b1, 1'b1, "R9");
    step(rnd72(), {4{18'd1}}, 2'd1, 1'b0, 1'b1, 1'b1, "R9");
    step(72'h0, 72'h0, 2'd0, 1'b0, 1'b0, 1'b1, "");
    step(72'h0, 72'h0, 2'd0, 1'b0, 1'b0, 1'b1, "");

    // R8: enable low with changing inputs holds output
    step(rnd72(), rnd72(), 2'd1, 1'b1, 1'b0, 1'b1, "");
    for (int s = 0; s < 3; s++)
      step(rnd72(), rnd72(), 2'd2, 1'b0, 1'b1, 1'b0, "");
    step(rnd72(), rnd72(), 2'd0, 1'b0, 1'b0, 1'b1, "");

    // random mix
    for (int n = 0; n < 600; n++) begin
      bit e  = ($urandom % 4) != 0;
      bit sh = ($urandom % 6) == 0;
      step(rnd72(), rnd72(), 2'($urandom % 4), 1'($urandom % 2), sh, e, "");
    end
    step(72'h0, 72'h0, 2'd0, 1'b0, 1'b0, 1'b1, "");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule